// File: doc/BRIEF.md
# Motor Command Frame Decoder

This block sits behind a byte-level serial slave and turns its write transactions into motor commands. The slave delivers three strobes: a start strobe, a byte strobe with eight data bits, and a stop strobe. The decoder first compares the address byte with a four-bit programmable identity and a strap bit. It then decodes the command code and checks each fixed padding byte. Only when the stop strobe closes a frame that matched in every byte does it issue one command. The commands are: load an absolute signed 16-bit target position, a soft stop, and a one-time-memory program request. A two-byte test-mode frame sets a sticky flag.

A soft stop can come from a frame or from a rising edge on the thermal-shutdown input. It holds a braking request until the motion logic reports that the motor has stopped. The decoder then copies the actual position into the target register. The test-mode flag blocks reads of the switch-input status, and only the power-on reset clears it. The functional reset leaves it set.

Frame states are IDLE, ADDR, CMD, D1, D2, D3, D4, DONE and DROP. The transitions are:
- A start strobe in any state goes to ADDR.
- A stop strobe goes to IDLE.
- In ADDR, a matching address byte goes to CMD; any other byte goes to DROP.
- In CMD, the set-position and program codes go to D1. The soft-stop and test codes go to DONE. Any other code goes to DROP.
- D1 and D2 go on only on 0xFF.
- D3 goes to D4. For a program frame it needs its upper five bits set to do so.
- D4 goes to DONE.
- Any byte in DONE goes to DROP, and DROP stays in DROP.

The brake unit has two states. It moves from RUN to BRAKE on a request and from BRAKE back to RUN when the motor reports it has stopped.

Top module: `mcf_decoder`

## Requirements
- R1: A frame is acted on only if its first byte equals {1,1,id_cfg[3],id_cfg[2],id_cfg[1],id_cfg[0],hw_strap,0} (bit 7 first). Any other first byte, including one with bit 0 = 1 (read), produces no output.
- R2: The frame address, 0x8B, 0xFF, 0xFF, H, L, stop with pos_gate_ok high sets target_pos to {H,L}. It also pulses cmd_set_pos for one cycle. Both are visible in the cycle after the stop strobe is sampled.
- R3: If pos_gate_ok is low at the stop strobe of a valid set-position frame, pos_ignored pulses for one cycle, cmd_set_pos stays low and target_pos is unchanged.
- R4: The two-byte frame address, 0x8F, stop raises soft_stop_req in the cycle after the stop strobe.
- R5: A rising edge of thermal_sd raises soft_stop_req one cycle later. A level held high raises no further request.
- R6: When soft_stop_req and motor_stopped are both high at a clock edge, the next cycle shows target_pos equal to the act_pos sampled at that edge, and soft_stop_req low. This copy takes precedence over a set-position load in the same cycle.
- R7: The frame address, 0x90, 0xFF, 0xFF, {11111,A[2:0]}, D, stop with vbb_ok high pulses otp_prog for one cycle, with otp_addr = A and otp_data = D.
- R8: The same frame with vbb_ok low pulses otp_err instead, and otp_prog stays low.
- R9: The frame is discarded without any output if a padding bit is cleared, the command code is unknown, a stop comes before the last byte, or a byte follows the last expected byte.
- R10: The frame address, TEST_CODE (default 0x9F), stop sets test_mode. test_mode stays set through rst_n and clears only on por_n.
- R11: sw_read_en follows sw_read_req while test_mode is low, and is held low while test_mode is high.
- R12: cmd_set_pos, pos_ignored, otp_prog and otp_err are single-cycle pulses, and at most one of them is high in any cycle.
- R13: A start strobe in the middle of a frame abandons it, and decoding restarts at the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low; also clears test mode |
| id_cfg | input | 4 | Programmable device identity |
| hw_strap | input | 1 | Hardware address strap bit |
| bus_start | input | 1 | Start condition strobe |
| bus_byte_vld | input | 1 | Received byte strobe |
| bus_byte | input | 8 | Received byte |
| bus_stop | input | 1 | Stop condition strobe |
| pos_gate_ok | input | 1 | Priority gate allowing a set-position command |
| vbb_ok | input | 1 | Supply in the programming window |
| thermal_sd | input | 1 | Thermal shutdown level |
| motor_stopped | input | 1 | Motion logic reports standstill |
| act_pos | input | 16 | Actual position |
| sw_read_req | input | 1 | Request to read the switch input |
| target_pos | output | 16 | Target position register |
| cmd_set_pos | output | 1 | Set-position command pulse |
| pos_ignored | output | 1 | Set-position blocked by the gate |
| soft_stop_req | output | 1 | Decelerate-and-stop request, held until standstill |
| otp_prog | output | 1 | Program request pulse |
| otp_addr | output | 3 | Program address |
| otp_data | output | 8 | Program data |
| otp_err | output | 1 | Program refused, supply out of window |
| test_mode | output | 1 | Sticky test-mode flag |
| sw_read_en | output | 1 | Switch-input read allowed |

## Verification
A wrong frame state shows up only at the stop strobe that closes the frame. A command is either lost or issued where none was due, in the cycle right after the stop. For that reason the bench sweeps every address byte and every command code, flips each padding bit, and stops each frame at every byte count. A brake or test-mode fault shows up one cycle after the thermal edge, the standstill report or the reset pulse, as a wrong target_pos, a wrong soft_stop_req or a wrong test_mode.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    localparam int BYTE_W = 8;
    localparam int POS_W  = 2 * BYTE_W;
    localparam int ID_W   = 4;
    localparam int OTPA_W = 3;

    localparam logic [BYTE_W-1:0] CODE_SET_POS   = 8'h8B;
    localparam logic [BYTE_W-1:0] CODE_SOFT_STOP = 8'h8F;
    localparam logic [BYTE_W-1:0] CODE_OTP_PROG  = 8'h90;
    localparam logic [BYTE_W-1:0] PAD_BYTE       = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_D1,
        ST_D2,
        ST_D3,
        ST_D4,
        ST_DONE,
        ST_DROP
    } frame_state_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_POS,
        K_STOP,
        K_OTP,
        K_TEST
    } cmd_kind_t;

    typedef enum logic {
        SS_RUN,
        SS_BRAKE
    } brake_state_t;

    typedef struct packed {
        logic              set_pos;
        logic              soft_stop;
        logic              otp;
        logic              test;
        logic [POS_W-1:0]  pos;
        logic [OTPA_W-1:0] otp_addr;
        logic [BYTE_W-1:0] otp_data;
    } frame_evt_t;

    function automatic logic [BYTE_W-1:0] addr_byte(input logic [ID_W-1:0] id,
                                                    input logic hw);
        return {2'b11, id, hw, 1'b0};
    endfunction

endpackage

// File: rtl/mcf_frame_fsm.sv
module mcf_frame_fsm
    import mcf_pkg::*;
#(
    parameter logic [7:0] TEST_CODE = 8'h9F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   id_cfg,
    input  logic              hw_strap,
    input  logic              bus_start,
    input  logic              bus_byte_vld,
    input  logic [BYTE_W-1:0] bus_byte,
    input  logic              bus_stop,
    output frame_evt_t        evt
);

    frame_state_t      state_q, state_d;
    cmd_kind_t         kind_q, kind_d;
    logic [BYTE_W-1:0] hi_q, lo_q;
    logic              is_pad;
    logic              otp_sel_ok;
    logic              closing;

    assign is_pad     = (bus_byte == PAD_BYTE);
    assign otp_sel_ok = &bus_byte[BYTE_W-1:OTPA_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_NONE;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        if (bus_start) begin
            state_d = ST_ADDR;
            kind_d  = K_NONE;
        end else if (bus_stop) begin
            state_d = ST_IDLE;
        end else if (bus_byte_vld) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: begin
                    if (bus_byte == addr_byte(id_cfg, hw_strap)) state_d = ST_CMD;
                    else                                         state_d = ST_DROP;
                end
                ST_CMD: begin
                    if (bus_byte == CODE_SET_POS) begin
                        state_d = ST_D1;
                        kind_d  = K_POS;
                    end else if (bus_byte == CODE_OTP_PROG) begin
                        state_d = ST_D1;
                        kind_d  = K_OTP;
                    end else if (bus_byte == CODE_SOFT_STOP) begin
                        state_d = ST_DONE;
                        kind_d  = K_STOP;
                    end else if (bus_byte == TEST_CODE) begin
                        state_d = ST_DONE;
                        kind_d  = K_TEST;
                    end else begin
                        state_d = ST_DROP;
                    end
                end
                ST_D1:   state_d = is_pad ? ST_D2 : ST_DROP;
                ST_D2:   state_d = is_pad ? ST_D3 : ST_DROP;
                ST_D3: begin
                    if (kind_q == K_OTP && !otp_sel_ok) state_d = ST_DROP;
                    else                                state_d = ST_D4;
                end
                ST_D4:   state_d = ST_DONE;
                ST_DONE: state_d = ST_DROP;
                ST_DROP: state_d = ST_DROP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // parameter bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (bus_byte_vld && !bus_start && !bus_stop) begin
            if (state_q == ST_D3) hi_q <= bus_byte;
            if (state_q == ST_D4) lo_q <= bus_byte;
        end
    end

    // outputs: only on the stop strobe that closes a complete frame
    assign closing = bus_stop && !bus_start && (state_q == ST_DONE);

    always_comb begin
        evt           = '0;
        evt.pos       = {hi_q, lo_q};
        evt.otp_addr  = hi_q[OTPA_W-1:0];
        evt.otp_data  = lo_q;
        evt.set_pos   = closing && (kind_q == K_POS);
        evt.soft_stop = closing && (kind_q == K_STOP);
        evt.otp       = closing && (kind_q == K_OTP);
        evt.test      = closing && (kind_q == K_TEST);
    end

    p_drop_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP && !bus_start && !bus_stop) |=> (state_q == ST_DROP));

    p_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (state_q == ST_ADDR));

    p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !bus_start) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/mcf_target_unit.sv
module mcf_target_unit
    import mcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_set_pos,
    input  logic             evt_soft_stop,
    input  logic [POS_W-1:0] evt_pos,
    input  logic             pos_gate_ok,
    input  logic             thermal_sd,
    input  logic             motor_stopped,
    input  logic [POS_W-1:0] act_pos,
    output logic [POS_W-1:0] target_pos,
    output logic             cmd_set_pos,
    output logic             pos_ignored,
    output logic             soft_stop_req
);

    brake_state_t     bst_q, bst_d;
    logic             therm_q;
    logic             therm_rise;
    logic             stop_new;
    logic             copy_now;
    logic [POS_W-1:0] target_q;
    logic             set_q, ign_q;

    assign therm_rise = thermal_sd && !therm_q;
    assign stop_new   = therm_rise || evt_soft_stop;
    assign copy_now   = (bst_q == SS_BRAKE) && motor_stopped;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bst_q   <= SS_RUN;
            therm_q <= 1'b0;
        end else begin
            bst_q   <= bst_d;
            therm_q <= thermal_sd;
        end
    end

    always_comb begin
        bst_d = bst_q;
        unique case (bst_q)
            SS_RUN:   if (stop_new) bst_d = SS_BRAKE;
            SS_BRAKE: if (!stop_new && motor_stopped) bst_d = SS_RUN;
            default:  bst_d = SS_RUN;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            set_q    <= 1'b0;
            ign_q    <= 1'b0;
        end else begin
            set_q <= evt_set_pos && pos_gate_ok;
            ign_q <= evt_set_pos && !pos_gate_ok;
            if (copy_now)                        target_q <= act_pos;
            else if (evt_set_pos && pos_gate_ok) target_q <= evt_pos;
        end
    end

    assign target_pos    = target_q;
    assign cmd_set_pos   = set_q;
    assign pos_ignored   = ign_q;
    assign soft_stop_req = (bst_q == SS_BRAKE);

    p_thermal_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        therm_rise |=> soft_stop_req);

    p_copy_actual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_stop_req && motor_stopped) |=> (target_pos == $past(act_pos)));

    p_gate_allows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_set_pos |-> $past(pos_gate_ok));

    p_ignored_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_ignored && !$past(copy_now)) |-> $stable(target_pos));

endmodule

// File: rtl/mcf_otp_port.sv
module mcf_otp_port
    import mcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_otp,
    input  logic [OTPA_W-1:0] evt_addr,
    input  logic [BYTE_W-1:0] evt_data,
    input  logic              vbb_ok,
    output logic              otp_prog,
    output logic [OTPA_W-1:0] otp_addr,
    output logic [BYTE_W-1:0] otp_data,
    output logic              otp_err
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            otp_prog <= 1'b0;
            otp_err  <= 1'b0;
            otp_addr <= '0;
            otp_data <= '0;
        end else begin
            otp_prog <= evt_otp && vbb_ok;
            otp_err  <= evt_otp && !vbb_ok;
            if (evt_otp && vbb_ok) begin
                otp_addr <= evt_addr;
                otp_data <= evt_data;
            end
        end
    end

    p_prog_needs_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        otp_prog |-> $past(vbb_ok));

    p_err_without_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        otp_err |-> !$past(vbb_ok));

endmodule

// File: rtl/mcf_test_latch.sv
module mcf_test_latch (
    input  logic clk,
    input  logic por_n,
    input  logic set_req,
    input  logic sw_read_req,
    output logic test_mode,
    output logic sw_read_en
);

    logic latch_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       latch_q <= 1'b0;
        else if (set_req) latch_q <= 1'b1;
    end

    assign test_mode  = latch_q;
    assign sw_read_en = sw_read_req && !latch_q;

    p_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
        test_mode |=> test_mode);

    p_set_r10: assert property (@(posedge clk) disable iff (!por_n)
        set_req |=> test_mode);

endmodule

// File: rtl/mcf_decoder.sv
module mcf_decoder
    import mcf_pkg::*;
#(
    parameter logic [7:0] TEST_CODE = 8'h9F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ID_W-1:0]   id_cfg,
    input  logic              hw_strap,
    input  logic              bus_start,
    input  logic              bus_byte_vld,
    input  logic [BYTE_W-1:0] bus_byte,
    input  logic              bus_stop,
    input  logic              pos_gate_ok,
    input  logic              vbb_ok,
    input  logic              thermal_sd,
    input  logic              motor_stopped,
    input  logic [POS_W-1:0]  act_pos,
    input  logic              sw_read_req,
    output logic [POS_W-1:0]  target_pos,
    output logic              cmd_set_pos,
    output logic              pos_ignored,
    output logic              soft_stop_req,
    output logic              otp_prog,
    output logic [OTPA_W-1:0] otp_addr,
    output logic [BYTE_W-1:0] otp_data,
    output logic              otp_err,
    output logic              test_mode,
    output logic              sw_read_en
);

    logic       rst_all_n;
    frame_evt_t evt;

    assign rst_all_n = rst_n && por_n;

    mcf_frame_fsm #(.TEST_CODE(TEST_CODE)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_all_n),
        .id_cfg       (id_cfg),
        .hw_strap     (hw_strap),
        .bus_start    (bus_start),
        .bus_byte_vld (bus_byte_vld),
        .bus_byte     (bus_byte),
        .bus_stop     (bus_stop),
        .evt          (evt)
    );

    mcf_target_unit u_target (
        .clk           (clk),
        .rst_n         (rst_all_n),
        .evt_set_pos   (evt.set_pos),
        .evt_soft_stop (evt.soft_stop),
        .evt_pos       (evt.pos),
        .pos_gate_ok   (pos_gate_ok),
        .thermal_sd    (thermal_sd),
        .motor_stopped (motor_stopped),
        .act_pos       (act_pos),
        .target_pos    (target_pos),
        .cmd_set_pos   (cmd_set_pos),
        .pos_ignored   (pos_ignored),
        .soft_stop_req (soft_stop_req)
    );

    mcf_otp_port u_otp (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .evt_otp  (evt.otp),
        .evt_addr (evt.otp_addr),
        .evt_data (evt.otp_data),
        .vbb_ok   (vbb_ok),
        .otp_prog (otp_prog),
        .otp_addr (otp_addr),
        .otp_data (otp_data),
        .otp_err  (otp_err)
    );

    mcf_test_latch u_test (
        .clk         (clk),
        .por_n       (por_n),
        .set_req     (evt.test),
        .sw_read_req (sw_read_req),
        .test_mode   (test_mode),
        .sw_read_en  (sw_read_en)
    );

    p_one_command_r12: assert property (@(posedge clk) disable iff (!rst_all_n)
        $onehot0({cmd_set_pos, pos_ignored, otp_prog, otp_err}));

    p_pulse_width_r12: assert property (@(posedge clk) disable iff (!rst_all_n)
        (cmd_set_pos || otp_prog) |=> !(cmd_set_pos || otp_prog));

    p_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_all_n)
        (cmd_set_pos || pos_ignored || otp_prog || otp_err) |-> $past(bus_stop));

endmodule

// File: tb/tb_mcf_decoder.sv
module tb_mcf_decoder;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] TCODE = 8'h9F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic [3:0]  id_cfg = 4'hA;
    logic        hw_strap = 1'b1;
    logic        bus_start = 0, bus_byte_vld = 0, bus_stop = 0;
    logic [7:0]  bus_byte = 8'h00;
    logic        pos_gate_ok = 1, vbb_ok = 1, thermal_sd = 0, motor_stopped = 0;
    logic [15:0] act_pos = 16'h0000;
    logic        sw_read_req = 0;
    logic [15:0] target_pos;
    logic        cmd_set_pos, pos_ignored, soft_stop_req, otp_prog, otp_err;
    logic [2:0]  otp_addr;
    logic [7:0]  otp_data;
    logic        test_mode, sw_read_en;

    int checks = 0;
    int errors = 0;
    logic c_set, c_ign, c_ss, c_prog, c_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcf_decoder #(.TEST_CODE(TCODE)) dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .id_cfg(id_cfg), .hw_strap(hw_strap),
        .bus_start(bus_start), .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte),
        .bus_stop(bus_stop), .pos_gate_ok(pos_gate_ok), .vbb_ok(vbb_ok),
        .thermal_sd(thermal_sd), .motor_stopped(motor_stopped), .act_pos(act_pos),
        .sw_read_req(sw_read_req), .target_pos(target_pos), .cmd_set_pos(cmd_set_pos),
        .pos_ignored(pos_ignored), .soft_stop_req(soft_stop_req), .otp_prog(otp_prog),
        .otp_addr(otp_addr), .otp_data(otp_data), .otp_err(otp_err),
        .test_mode(test_mode), .sw_read_en(sw_read_en)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] my_addr();
        return {2'b11, id_cfg, hw_strap, 1'b0};
    endfunction

    // sends n bytes from bs (first byte in the top bits), then stop; samples the cycle after stop
    task automatic run_frame(input int n, input logic [47:0] bs);
        bus_start = 1; @(negedge clk); bus_start = 0;
        for (int i = 0; i < n; i++) begin
            bus_byte = bs[47-8*i -: 8];
            bus_byte_vld = 1; @(negedge clk); bus_byte_vld = 0;
        end
        bus_stop = 1; @(negedge clk); bus_stop = 0;
        c_set = cmd_set_pos; c_ign = pos_ignored; c_ss = soft_stop_req;
        c_prog = otp_prog; c_err = otp_err;
        @(negedge clk);
        chk(!(cmd_set_pos | pos_ignored | otp_prog | otp_err), "R12 pulse width",
            {cmd_set_pos, pos_ignored, otp_prog, otp_err}, 0);
    endtask

    task automatic release_stop(input logic [15:0] ap);
        act_pos = ap; motor_stopped = 1; @(negedge clk); motor_stopped = 0;
        chk(target_pos == ap, "R6 copy actual", target_pos, ap);
        chk(!soft_stop_req, "R6 request drop", soft_stop_req, 0);
    endtask

    task automatic set_pos(input logic [15:0] p);
        run_frame(6, {my_addr(), 8'h8B, 8'hFF, 8'hFF, p});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] old;
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;
        @(negedge clk);
        chk(target_pos == 0 && !soft_stop_req && !test_mode && !cmd_set_pos && !otp_prog,
            "R12 reset state", {target_pos, soft_stop_req, test_mode}, 0);

        // R1: sweep every first byte for two identity settings
        for (int cfg = 0; cfg < 2; cfg++) begin
            id_cfg = cfg ? 4'h5 : 4'hA;
            hw_strap = cfg ? 1'b0 : 1'b1;
            for (int a = 0; a < 256; a++) begin
                logic exp_hit;
                exp_hit = (a[7:0] == my_addr());
                run_frame(2, {a[7:0], 8'h8F, 32'h0});
                chk(c_ss == exp_hit, "R1 address match", c_ss, exp_hit);
                if (soft_stop_req) release_stop(16'h4000 + 16'(a));
            end
        end

        // R4/R9: sweep command codes in a two-byte frame
        for (int c = 0; c < 256; c++) begin
            if (c[7:0] != TCODE) begin
                logic exp_ss;
                exp_ss = (c[7:0] == 8'h8F);
                run_frame(2, {my_addr(), c[7:0], 32'h0});
                chk(c_ss == exp_ss && !c_set && !c_prog && !c_err, "R4 command code", c_ss, exp_ss);
                if (soft_stop_req) release_stop(16'h1000 + 16'(c));
            end
        end

        // R2: set position values
        pos_gate_ok = 1;
        for (int k = 0; k < 8; k++) begin
            logic [15:0] p;
            p = (k == 0) ? 16'h0000 : (k == 1) ? 16'h7FFF : (k == 2) ? 16'h8000 :
                (k == 3) ? 16'hFFFF : 16'(k * 16'h1357 + 3);
            set_pos(p);
            chk(c_set && !c_ign, "R2 command pulse", c_set, 1);
            chk(target_pos == p, "R2 target load", target_pos, p);
        end

        // R3: gate blocks
        old = target_pos;
        pos_gate_ok = 0;
        set_pos(16'h2468);
        chk(c_ign && !c_set, "R3 ignored pulse", {c_ign, c_set}, 2);
        chk(target_pos == old, "R3 target kept", target_pos, old);
        pos_gate_ok = 1;

        // R9: padding bit flips
        for (int b = 0; b < 16; b++) begin
            logic [15:0] pad;
            pad = 16'hFFFF ^ (16'h1 << b);
            set_pos(16'h0F0F);
            old = target_pos;
            run_frame(6, {my_addr(), 8'h8B, pad, 16'h1111});
            chk(!c_set && target_pos == old, "R9 padding", target_pos, old);
        end

        // R9: early stop at every count, and an extra byte
        for (int n = 0; n < 6; n++) begin
            run_frame(n, {my_addr(), 8'h8B, 8'hFF, 8'hFF, 16'h5555});
            chk(!c_set && !c_ign && target_pos == 16'h0F0F, "R9 short frame", target_pos, 16'h0F0F);
        end
        bus_start = 1; @(negedge clk); bus_start = 0;
        run_frame(0, 48'h0);
        run_frame(6, {my_addr(), 8'h8B, 8'hFF, 8'hFF, 16'h5555});
        chk(c_set && target_pos == 16'h5555, "R2 after aborts", target_pos, 16'h5555);
        set_pos(16'h0F0F);
        bus_start = 1; @(negedge clk); bus_start = 0;
        foreach (old[i]) ;
        begin
            logic [7:0] ex [7];
            ex = '{my_addr(), 8'h8B, 8'hFF, 8'hFF, 8'h33, 8'h44, 8'h00};
            for (int i = 0; i < 7; i++) begin
                bus_byte = ex[i]; bus_byte_vld = 1; @(negedge clk); bus_byte_vld = 0;
            end
            bus_stop = 1; @(negedge clk); bus_stop = 0;
            chk(!cmd_set_pos && target_pos == 16'h0F0F, "R9 extra byte", target_pos, 16'h0F0F);
        end
        run_frame(3, {my_addr(), 8'h8F, 8'h00, 24'h0});
        chk(!c_ss, "R9 extra byte soft stop", c_ss, 0);

        // R13: restart mid-frame
        bus_start = 1; @(negedge clk); bus_start = 0;
        bus_byte = my_addr(); bus_byte_vld = 1; @(negedge clk);
        bus_byte = 8'h8B; @(negedge clk); bus_byte_vld = 0;
        run_frame(2, {my_addr(), 8'h8F, 32'h0});
        chk(c_ss && !c_set, "R13 restart", c_ss, 1);
        release_stop(16'hABCD);

        // R7/R8: program frames
        for (int a = 0; a < 8; a++) begin
            logic [7:0] d;
            d = 8'(a * 37 + 5);
            vbb_ok = 1;
            run_frame(6, {my_addr(), 8'h90, 8'hFF, 8'hFF, 5'h1F, a[2:0], d});
            chk(c_prog && !c_err && otp_addr == a[2:0] && otp_data == d, "R7 program",
                {c_prog, otp_addr, otp_data}, {1'b1, a[2:0], d});
            vbb_ok = 0;
            run_frame(6, {my_addr(), 8'h90, 8'hFF, 8'hFF, 5'h1F, a[2:0], d});
            chk(c_err && !c_prog, "R8 supply low", {c_err, c_prog}, 2);
        end
        vbb_ok = 1;
        for (int b = 3; b < 8; b++) begin
            logic [7:0] sel;
            sel = 8'hFF ^ (8'h1 << b);
            run_frame(6, {my_addr(), 8'h90, 8'hFF, 8'hFF, sel, 8'h77});
            chk(!c_prog && !c_err, "R9 program select bits", {c_prog, c_err}, 0);
        end

        // R5: thermal edge
        thermal_sd = 1; @(negedge clk);
        chk(soft_stop_req, "R5 thermal edge", soft_stop_req, 1);
        release_stop(16'h7777);
        repeat (3) @(negedge clk);
        chk(!soft_stop_req, "R5 level no repeat", soft_stop_req, 0);
        thermal_sd = 0; @(negedge clk);

        // R11/R10: test mode
        sw_read_req = 1; @(negedge clk);
        chk(sw_read_en, "R11 read allowed", sw_read_en, 1);
        run_frame(2, {my_addr(), TCODE, 32'h0});
        chk(test_mode, "R10 test entry", test_mode, 1);
        chk(!sw_read_en, "R11 read blocked", sw_read_en, 0);
        rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
        chk(test_mode && !sw_read_en, "R10 survives rst_n", test_mode, 1);
        set_pos(16'h1234);
        chk(c_set && target_pos == 16'h1234, "R2 in test mode", target_pos, 16'h1234);
        por_n = 0; @(negedge clk); @(negedge clk); por_n = 1; @(negedge clk);
        chk(!test_mode && sw_read_en, "R10 cleared by por_n", test_mode, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule